// File: doc/BRIEF.md
# Debug Run-Control Register

This block is a single memory-mapped control and status word that a debugger uses to stop, single-step and resume a processor core. A debugger writes 32-bit words over a simple register bus to enable halting debug, request a halt or a run, arm single-step, mask the lower-priority interrupt sources while stepping, and request a forced (imprecise) entry into the halted state. The block turns these control bits into registered request lines toward the core. A write changes anything only when a 16-bit key sits in the upper half of the data.

Reading the same word returns the control bits together with status gathered from the core: halted, sleeping, locked up, a ready flag for core-register transfers, and two sticky event flags. The sticky flags record that an instruction retired or that a reset happened. Reading the word clears both. A write to a second address, the core-register selector, clears the ready flag, and the core sets it again when the transfer is done. The transfer datapath itself is not part of the block.

Top module: `dbg_run_ctrl`

## Requirements
- R1: A write to the control address whose data bits 31:16 differ from the key (default 0xA05F) leaves every control bit unchanged.
- R2: A keyed write loads debug-enable from data bit 0, halt from bit 1, step from bit 2 and stall-entry from bit 5. These bits read back at the same positions, and bit 4 reads 0.
- R3: Interrupt-mask (bit 3) takes the written value only when halt was already 1 before the write and the same write sets bit 1 to 1. Otherwise the mask keeps its value.
- R4: A read of the control address returns ready at bit 16, halted at bit 17, sleeping at bit 18, locked-up at bit 19, retired at bit 24 and reset-seen at bit 25, each reflecting the core input registered one cycle earlier. All other bits from 6 to 31 read 0. A read of any other address returns 0.
- R5: The retired and reset-seen flags are set by a one-cycle event pulse and cleared by a read of the control address. When an event arrives in the same cycle as the read, the flag stays 1.
- R6: Any write to the selector address clears the ready flag. A transfer-done pulse sets it. If both occur in the same cycle, the flag is cleared.
- R7: The locked-up status reads 0 whenever the core reported itself halted in the previous cycle.
- R8: After power-on reset all control bits and outputs are 0, both sticky flags are 0, ready is 1 and read data is 0.
- R9: A system-reset pulse clears only the halt bit. This takes precedence over a write in the same cycle, and every other control bit keeps its value.
- R10: The halt request output is 1 only while debug-enable and halt are both 1. The step request output is 1 only while debug-enable and step are 1 and halt is 0. Both outputs update on the same edge as the control bits.
- R11: Read data appears on the cycle after the read strobe, shows the values held before that read's clear, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sys_rst | input | 1 | System-reset pulse; clears the halt bit only |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; key in bits 31:16 |
| bus_rdata | output | 32 | Registered read data |
| core_halted | input | 1 | Core is in the halted state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_retired | input | 1 | Pulse: an instruction completed |
| core_reset_seen | input | 1 | Pulse: core went through a reset |
| xfer_done | input | 1 | Pulse: core-register transfer completed |
| dbg_en_o | output | 1 | Halting debug enabled |
| halt_req_o | output | 1 | Halt request to the core |
| step_req_o | output | 1 | Single-step request to the core |
| irq_mask_o | output | 1 | Mask lower-priority interrupts in the core |
| snap_stall_o | output | 1 | Request forced entry to the halted state |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the control word at 0xF0, the selector at 0xF4 and the key 0xA05F. The stimulus also uses a third address that hits neither register, so the address decode and the zero read are covered. Random traffic mixes correct and wrong keys, collisions between events and reads, and collisions between selector writes and transfer-done pulses. The 8-bit address space is small, so every address case comes up often.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int DATA_W   = 32;
  localparam int KEY_W    = 16;
  // read-back bit positions (decoded by the debugger)
  localparam int B_EN     = 0;
  localparam int B_HALT   = 1;
  localparam int B_STEP   = 2;
  localparam int B_MASK   = 3;
  localparam int B_SNAP   = 5;
  localparam int B_RDY    = 16;
  localparam int B_HALTED = 17;
  localparam int B_SLEEP  = 18;
  localparam int B_LOCK   = 19;
  localparam int B_RET    = 24;
  localparam int B_RST    = 25;
  // sticky event indices
  localparam int N_STICKY = 2;
  localparam int S_RET    = 0;
  localparam int S_RST    = 1;

  typedef struct packed {
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dbgc_ctrl.sv
module dbgc_ctrl
  import dbgc_pkg::*;
#(
  parameter int                KW  = KEY_W,
  parameter logic [KW-1:0]     KEY = 16'hA05F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_rst,
  input  logic          wr_hit,
  input  logic [KW-1:0] key_in,
  input  ctrl_t         wr_fields,
  output ctrl_t         ctrl_q,
  output logic          halt_req_o,
  output logic          step_req_o
);
  logic  key_ok;
  logic  mask_ok;
  ctrl_t nxt;

  assign key_ok  = (key_in == KEY);
  assign mask_ok = ctrl_q.halt && wr_fields.halt;

  always_comb begin
    nxt = ctrl_q;
    if (wr_hit && key_ok) begin
      nxt.en   = wr_fields.en;
      nxt.halt = wr_fields.halt;
      nxt.step = wr_fields.step;
      nxt.snap = wr_fields.snap;
      if (mask_ok) nxt.mask = wr_fields.mask;
    end
    if (sys_rst) nxt.halt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      halt_req_o <= 1'b0;
      step_req_o <= 1'b0;
    end else begin
      ctrl_q     <= nxt;
      halt_req_o <= nxt.en && nxt.halt;
      step_req_o <= nxt.en && nxt.step && !nxt.halt;
    end
  end

  // R1: an unkeyed write changes nothing
  a_r1_badkey_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !key_ok && !sys_rst) |=> $stable(ctrl_q));
  // R3: mask moves only under a halted, halt-keeping keyed write
  a_r3_mask_guard: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && key_ok && ctrl_q.halt && wr_fields.halt) |=> $stable(ctrl_q.mask));
  // R9: system reset drops halt
  a_r9_sysrst_halt: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !ctrl_q.halt);
  // R10: requests gated by enable, never both
  a_r10_halt_needs_en: assert property (@(posedge clk) disable iff (rst)
    halt_req_o |-> (ctrl_q.en && ctrl_q.halt));
  a_r10_req_excl: assert property (@(posedge clk) disable iff (rst)
    !(halt_req_o && step_req_o));
endmodule

// File: rtl/dbgc_sticky.sv
module dbgc_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_clr,
  input  logic [N-1:0] ev,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= 1'b0;
      else if (ev[i]) q[i] <= 1'b1;
      else if (rd_clr) q[i] <= 1'b0;
    end
    // R5: event sets, read clears when no event
    a_r5_set: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> q[i]);
    a_r5_clr: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !ev[i]) |=> !q[i]);
  end
endmodule

// File: rtl/dbgc_status.sv
module dbgc_status
  import dbgc_pkg::*;
#(
  parameter int NS = N_STICKY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_halted_i,
  input  logic          core_sleep_i,
  input  logic          core_lock_i,
  input  logic [NS-1:0] ev_i,
  input  logic          rd_clr,
  input  logic          sel_wr,
  input  logic          xfer_done,
  output logic          halted_q,
  output logic          sleep_q,
  output logic          lock_q,
  output logic          rdy_q,
  output logic [NS-1:0] stk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      sleep_q  <= 1'b0;
      lock_q   <= 1'b0;
      rdy_q    <= 1'b1;
    end else begin
      halted_q <= core_halted_i;
      sleep_q  <= core_sleep_i;
      lock_q   <= core_lock_i && !core_halted_i;
      if (sel_wr)         rdy_q <= 1'b0;
      else if (xfer_done) rdy_q <= 1'b1;
    end
  end

  dbgc_sticky #(.N(NS)) i_sticky (
    .clk    (clk),
    .rst    (rst),
    .rd_clr (rd_clr),
    .ev     (ev_i),
    .q      (stk_q)
  );

  // R6: selector write clears, completion sets
  a_r6_sel_clear: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> !rdy_q);
  a_r6_done_set: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !sel_wr) |=> rdy_q);
  // R7: no lock-up status while halted
  a_r7_lock_halted: assert property (@(posedge clk) disable iff (rst)
    core_halted_i |=> !lock_q);
endmodule

// File: rtl/dbgc_rdmux.sv
module dbgc_rdmux
  import dbgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ctrl,
  input  logic              rd_other,
  input  ctrl_t             ctrl,
  input  logic              halted,
  input  logic              sleep,
  input  logic              lock,
  input  logic              rdy,
  input  logic [N_STICKY-1:0] stk,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word           = '0;
    word[B_EN]     = ctrl.en;
    word[B_HALT]   = ctrl.halt;
    word[B_STEP]   = ctrl.step;
    word[B_MASK]   = ctrl.mask;
    word[B_SNAP]   = ctrl.snap;
    word[B_RDY]    = rdy;
    word[B_HALTED] = halted;
    word[B_SLEEP]  = sleep;
    word[B_LOCK]   = lock;
    word[B_RET]    = stk[S_RET];
    word[B_RST]    = stk[S_RST];
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_o <= '0;
    else if (rd_ctrl)  rdata_o <= word;
    else if (rd_other) rdata_o <= '0;
  end

  // R11: read data holds between reads
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_ctrl || rd_other) |=> $stable(rdata_o));
  // R4: unused positions stay zero
  a_r4_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (rdata_o[4] == 1'b0) && (rdata_o[15:6] == '0) && (rdata_o[23:20] == '0)
    && (rdata_o[31:26] == '0));
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbgc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF0,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'hF4,
  parameter logic [KEY_W-1:0]  WR_KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              core_halted,
  input  logic              core_sleeping,
  input  logic              core_lockup,
  input  logic              core_retired,
  input  logic              core_reset_seen,
  input  logic              xfer_done,
  output logic              dbg_en_o,
  output logic              halt_req_o,
  output logic              step_req_o,
  output logic              irq_mask_o,
  output logic              snap_stall_o
);
  logic                hit_ctrl, hit_sel;
  logic                wr_ctrl, sel_wr, rd_ctrl, rd_other;
  ctrl_t               wr_fields, ctrl_q;
  logic                halted_q, sleep_q, lock_q, rdy_q;
  logic [N_STICKY-1:0] ev, stk_q;
  logic                unused_wbits;

  assign hit_ctrl = (bus_addr == CTRL_ADDR);
  assign hit_sel  = (bus_addr == SEL_ADDR);
  assign wr_ctrl  = bus_wr && hit_ctrl;
  assign sel_wr   = bus_wr && hit_sel;
  assign rd_ctrl  = bus_rd && hit_ctrl;
  assign rd_other = bus_rd && !hit_ctrl;

  assign wr_fields.en   = bus_wdata[B_EN];
  assign wr_fields.halt = bus_wdata[B_HALT];
  assign wr_fields.step = bus_wdata[B_STEP];
  assign wr_fields.mask = bus_wdata[B_MASK];
  assign wr_fields.snap = bus_wdata[B_SNAP];
  assign unused_wbits   = ^{bus_wdata[15:6], bus_wdata[4]};

  assign ev[S_RET] = core_retired;
  assign ev[S_RST] = core_reset_seen;

  dbgc_ctrl #(.KW(KEY_W), .KEY(WR_KEY)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sys_rst    (sys_rst),
    .wr_hit     (wr_ctrl),
    .key_in     (bus_wdata[DATA_W-1 -: KEY_W]),
    .wr_fields  (wr_fields),
    .ctrl_q     (ctrl_q),
    .halt_req_o (halt_req_o),
    .step_req_o (step_req_o)
  );

  dbgc_status #(.NS(N_STICKY)) i_status (
    .clk           (clk),
    .rst           (rst),
    .core_halted_i (core_halted),
    .core_sleep_i  (core_sleeping),
    .core_lock_i   (core_lockup),
    .ev_i          (ev),
    .rd_clr        (rd_ctrl),
    .sel_wr        (sel_wr),
    .xfer_done     (xfer_done),
    .halted_q      (halted_q),
    .sleep_q       (sleep_q),
    .lock_q        (lock_q),
    .rdy_q         (rdy_q),
    .stk_q         (stk_q)
  );

  dbgc_rdmux i_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_ctrl  (rd_ctrl),
    .rd_other (rd_other),
    .ctrl     (ctrl_q),
    .halted   (halted_q),
    .sleep    (sleep_q),
    .lock     (lock_q),
    .rdy      (rdy_q),
    .stk      (stk_q),
    .rdata_o  (bus_rdata)
  );

  assign dbg_en_o     = ctrl_q.en;
  assign irq_mask_o   = ctrl_q.mask;
  assign snap_stall_o = ctrl_q.snap;
endmodule

// File: tb/test_dbg_run_ctrl.sv
module test_dbg_run_ctrl;
  localparam logic [7:0]  A_CTRL = 8'hF0;
  localparam logic [7:0]  A_SEL  = 8'hF4;
  localparam logic [7:0]  A_NONE = 8'h10;
  localparam logic [31:0] KEYW   = 32'hA05F_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, sys_rst, bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        c_halt, c_sleep, c_lock, c_ret, c_rst, x_done;
  logic        dbg_en_o, halt_req_o, step_req_o, irq_mask_o, snap_stall_o;

  dbg_run_ctrl i_dbg_run_ctrl (
    .clk(clk), .rst(rst), .sys_rst(sys_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_halted(c_halt), .core_sleeping(c_sleep), .core_lockup(c_lock),
    .core_retired(c_ret), .core_reset_seen(c_rst), .xfer_done(x_done),
    .dbg_en_o(dbg_en_o), .halt_req_o(halt_req_o), .step_req_o(step_req_o),
    .irq_mask_o(irq_mask_o), .snap_stall_o(snap_stall_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic m_en, m_halt, m_step, m_mask, m_snap, m_hq, m_sl, m_lk, m_ret, m_rs, m_rdy;
  logic m_hreq, m_sreq;
  logic [31:0] m_rdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_word();
    logic [31:0] v = '0;
    v[0] = m_en; v[1] = m_halt; v[2] = m_step; v[3] = m_mask; v[5] = m_snap;
    v[16] = m_rdy; v[17] = m_hq; v[18] = m_sl; v[19] = m_lk;
    v[24] = m_ret; v[25] = m_rs;
    return v;
  endfunction

  task automatic model_edge();
    logic rdc, wk, pre_halt;
    rdc = bus_rd && (bus_addr == A_CTRL);
    pre_halt = m_halt;
    if (rst) begin
      {m_en, m_halt, m_step, m_mask, m_snap} = '0;
      {m_hq, m_sl, m_lk, m_ret, m_rs} = '0;
      m_rdy = 1'b1; m_rdata = '0;
    end else begin
      if (rdc) m_rdata = pack_word();
      else if (bus_rd) m_rdata = '0;
      wk = bus_wr && (bus_addr == A_CTRL) && (bus_wdata[31:16] == 16'hA05F);
      if (wk) begin
        m_en = bus_wdata[0]; m_halt = bus_wdata[1]; m_step = bus_wdata[2];
        m_snap = bus_wdata[5];
        if (pre_halt && bus_wdata[1]) m_mask = bus_wdata[3];
      end
      if (sys_rst) m_halt = 1'b0;
      m_hq = c_halt; m_sl = c_sleep; m_lk = c_lock && !c_halt;
      m_ret = c_ret ? 1'b1 : (rdc ? 1'b0 : m_ret);
      m_rs  = c_rst ? 1'b1 : (rdc ? 1'b0 : m_rs);
      if (bus_wr && (bus_addr == A_SEL)) m_rdy = 1'b0;
      else if (x_done) m_rdy = 1'b1;
    end
    m_hreq = m_en && m_halt;
    m_sreq = m_en && m_step && !m_halt;
  endtask

  task automatic compare_outputs();
    chk(bus_rdata === m_rdata, "R4 read word", bus_rdata, m_rdata);
    chk(halt_req_o === m_hreq, "R10 halt request", {31'b0, halt_req_o}, {31'b0, m_hreq});
    chk(step_req_o === m_sreq, "R10 step request", {31'b0, step_req_o}, {31'b0, m_sreq});
    chk(irq_mask_o === m_mask, "R3 mask output", {31'b0, irq_mask_o}, {31'b0, m_mask});
    chk({dbg_en_o, snap_stall_o} === {m_en, m_snap}, "R2 enable/stall outputs",
        {30'b0, dbg_en_o, snap_stall_o}, {30'b0, m_en, m_snap});
  endtask

  // one clock: inputs already driven after a negedge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_outputs();
    bus_wr = 0; bus_rd = 0; sys_rst = 0; c_ret = 0; c_rst = 0; x_done = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step();
  endtask

  task automatic rd_ctrl_word();
    bus_addr = A_CTRL; bus_rd = 1; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1; sys_rst = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    c_halt = 0; c_sleep = 0; c_lock = 0; c_ret = 0; c_rst = 0; x_done = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();
    rst = 0;

    // R8: reset state
    chk({dbg_en_o, halt_req_o, step_req_o, irq_mask_o, snap_stall_o} == 5'b0,
        "R8 outputs after reset", {27'b0, dbg_en_o, halt_req_o, step_req_o, irq_mask_o, snap_stall_o}, 32'h0);
    rd_ctrl_word();
    chk(bus_rdata == 32'h0001_0000, "R8 reset word", bus_rdata, 32'h0001_0000);

    // R1: wrong key
    wr(A_CTRL, 32'h1234_0023);
    rd_ctrl_word();
    chk(bus_rdata == 32'h0001_0000, "R1 bad key ignored", bus_rdata, 32'h0001_0000);

    // R2 / R10: keyed write of enable, halt, stall
    wr(A_CTRL, KEYW | 32'h23);
    chk(halt_req_o == 1 && snap_stall_o == 1, "R10 halt request raised", {30'b0, halt_req_o, snap_stall_o}, 32'h3);
    rd_ctrl_word();
    chk(bus_rdata == 32'h0001_0023, "R2 field read-back", bus_rdata, 32'h0001_0023);

    // R3: mask rules
    wr(A_CTRL, KEYW | 32'h0B);
    chk(irq_mask_o == 1, "R3 mask set while halted", {31'b0, irq_mask_o}, 32'h1);
    wr(A_CTRL, KEYW | 32'h01);
    chk(irq_mask_o == 1 && halt_req_o == 0, "R3 mask kept on run write", {30'b0, irq_mask_o, halt_req_o}, 32'h2);
    wr(A_CTRL, KEYW | 32'h0B);
    chk(irq_mask_o == 1, "R3 mask kept, halt was 0", {31'b0, irq_mask_o}, 32'h1);
    wr(A_CTRL, KEYW | 32'h03);
    chk(irq_mask_o == 0, "R3 mask cleared while halted", {31'b0, irq_mask_o}, 32'h0);

    // R10: enable gating and step
    wr(A_CTRL, KEYW | 32'h02);
    chk(halt_req_o == 0, "R10 halt blocked without enable", {31'b0, halt_req_o}, 32'h0);
    wr(A_CTRL, KEYW | 32'h05);
    chk(step_req_o == 1 && halt_req_o == 0, "R10 step request", {30'b0, step_req_o, halt_req_o}, 32'h2);

    // R9: system reset clears halt only
    wr(A_CTRL, KEYW | 32'h07);
    sys_rst = 1; bus_addr = A_CTRL; bus_wdata = KEYW | 32'h07; bus_wr = 1; step();
    rd_ctrl_word();
    chk(bus_rdata[2:0] == 3'b101, "R9 only halt cleared", {29'b0, bus_rdata[2:0]}, 32'h5);

    // R5 / R11: sticky flags
    rd_ctrl_word();
    c_ret = 1; step();
    rd_ctrl_word();
    chk(bus_rdata[24] == 1, "R5 retired sticky set", bus_rdata, 32'h0100_0000);
    rd_ctrl_word();
    chk(bus_rdata[24] == 0, "R5 retired cleared by read", bus_rdata, 32'h0);
    c_rst = 1; bus_addr = A_CTRL; bus_rd = 1; step();
    chk(bus_rdata[25] == 0, "R11 read shows pre-event value", bus_rdata, 32'h0);
    rd_ctrl_word();
    chk(bus_rdata[25] == 1, "R5 event wins over read clear", bus_rdata, 32'h0200_0000);

    // R6: ready handshake
    wr(A_SEL, 32'h0000_0011);
    rd_ctrl_word();
    chk(bus_rdata[16] == 0, "R6 selector write clears ready", bus_rdata, 32'h0);
    x_done = 1; step();
    rd_ctrl_word();
    chk(bus_rdata[16] == 1, "R6 done sets ready", bus_rdata, 32'h0001_0000);
    x_done = 1; bus_addr = A_SEL; bus_wr = 1; step();
    rd_ctrl_word();
    chk(bus_rdata[16] == 0, "R6 selector wins over done", bus_rdata, 32'h0);

    // R7 / R4: lock-up and other status
    c_lock = 1; c_sleep = 1; step();
    rd_ctrl_word();
    chk(bus_rdata[19:18] == 2'b11, "R4 lockup and sleep bits", {30'b0, bus_rdata[19:18]}, 32'h3);
    c_halt = 1; step();
    rd_ctrl_word();
    chk(bus_rdata[19:17] == 3'b011, "R7 lockup hidden while halted", {29'b0, bus_rdata[19:17]}, 32'h3);
    bus_addr = A_NONE; bus_rd = 1; step();
    chk(bus_rdata == 32'h0, "R4 other address reads zero", bus_rdata, 32'h0);

    // random traffic against the model
    void'($urandom(32'd7331));
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom_range(0, 2);
      bus_addr = (sel == 0) ? A_CTRL : (sel == 1) ? A_SEL : A_NONE;
      if ($urandom_range(0, 3) == 0) bus_addr = A_CTRL;
      bus_wr = ($urandom_range(0, 9) < 3);
      bus_rd = ($urandom_range(0, 9) < 4);
      bus_wdata = {($urandom_range(0, 3) != 0) ? 16'hA05F : 16'($urandom),
                   16'($urandom)};
      c_halt = $urandom_range(0, 1); c_sleep = $urandom_range(0, 1);
      c_lock = $urandom_range(0, 1);
      c_ret = ($urandom_range(0, 4) == 0); c_rst = ($urandom_range(0, 6) == 0);
      x_done = ($urandom_range(0, 4) == 0);
      sys_rst = ($urandom_range(0, 30) == 0);
      step();
    end
    finish_run();
  end
endmodule